// File: doc/BRIEF.md
# Parallel Port Receive Handshake

This block sits between a host's parallel printer cable and a printer controller's CPU. The host puts a byte on the 8-bit data lines and pulses an active-low strobe. The block samples the strobe into the system clock domain, latches the byte on the strobe's leading edge, and raises a hardware busy flag on its own, with no CPU action. Firmware chooses whether that flag rises on the strobe's leading edge or on its trailing edge.

The BUSY pin seen by the host is the OR of the hardware flag and a busy bit that firmware writes, so firmware can hold off the host while it is occupied. A small register port lets the CPU read the latched byte and a status word, clear the received flag and the sticky overrun flag, and set the edge mode and the firmware busy bit. A separate active-low initialise input returns the receive logic to its idle state.

Top module: `pport_rx_hshk`

## Requirements
- R1: After `rst`, `busy` is 1, the data register reads 0x00, status reads 0x04 and control reads 0x02.
- R2: With default parameters, the byte on `pdata` is latched at the third rising clock edge that samples `strobe_n` low. It is held until the next leading edge, and the strobe is synchronised through two flops.
- R3: When control bit0 (the edge mode) is 0, the received flag (status bit0) sets on the same clock edge that latches the byte. `busy` follows one clock later.
- R4: When control bit0 is 1, the leading edge still latches the byte but leaves the received flag alone. The flag sets at the third rising edge that samples `strobe_n` high again.
- R5: `busy` is a register that takes the OR of the received flag and the firmware busy bit (control bit1), one clock after either one changes.
- R6: Writing status with bit0 = 1 clears the received flag. Reading any register changes no state.
- R7: A leading edge that arrives while the received flag is set overwrites the data register and sets the overrun flag (status bit1). The overrun flag stays set until status is written with bit1 = 1.
- R8: When a strobe event and a clearing status write fall on the same clock edge, the set wins. This holds for the received flag and for the overrun flag.
- R9: While `init_n` is low, the received and overrun flags are held at 0, the firmware busy bit is forced to 1, `busy` is 1 one clock later, and no byte is latched. The edge mode keeps its value.
- R10: Register map: address 0 holds the data byte, address 1 holds status {bit2 `busy`, bit1 overrun, bit0 received}, address 2 holds control {bit1 firmware busy, bit0 edge mode}, and address 3 reads 0. `cpu_rdata` is loaded on a read cycle with the register values from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_n | input | 1 | Active-low initialise, synchronous |
| strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| pdata | input | 8 | Host data lines |
| busy | output | 1 | BUSY to the host, registered |
| cpu_sel | input | 1 | CPU register access this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 2 | Write data (command and control bits) |
| cpu_rdata | output | 8 | Registered read data |

## Verification
Two events can land on one clock edge: a strobe event that sets the received or overrun flag, and a CPU status write that clears the same flag. The bench provokes this by counting clocks from the strobe's falling edge, so that the clearing write is presented exactly at the third sampling edge. It then expects status to read 0x07, because the set wins over the clear. A cycle-by-cycle behavioural model checks `busy` and `cpu_rdata` on every clock, including during random traffic where clears and strobes overlap by chance.

// File: rtl/pport_rx_pkg.sv
package pport_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CMD_W  = 2;
  localparam int unsigned REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd2;

  // status bit positions
  localparam int unsigned ST_RX   = 0;
  localparam int unsigned ST_OVR  = 1;
  localparam int unsigned ST_BUSY = 2;
  // control bit positions
  localparam int unsigned CT_EDGE = 0;
  localparam int unsigned CT_SWB  = 1;
endpackage

// File: rtl/pport_strb_sync.sv
module pport_strb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic lead,
  output logic trail
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= strobe_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[LAST];
  end

  // strobe is active low: leading edge is high-to-low
  assign lead  = prev & ~chain[LAST];
  assign trail = ~prev & chain[LAST];
endmodule

// File: rtl/pport_rx_core.sv
module pport_rx_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_n,
  input  logic              lead,
  input  logic              trail,
  input  logic              edge_sel,
  input  logic [DATA_W-1:0] pdata,
  input  logic              clr_rx,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] data_q,
  output logic              hw_busy,
  output logic              ovr
);
  logic set_ev;
  logic ovr_ev;

  assign set_ev = edge_sel ? trail : lead;
  assign ovr_ev = lead & hw_busy;

  always_ff @(posedge clk) begin
    if (rst)                 data_q <= '0;
    else if (init_n && lead) data_q <= pdata;
  end

  // set dominates clear
  always_ff @(posedge clk) begin
    if (rst || !init_n) hw_busy <= 1'b0;
    else if (set_ev)    hw_busy <= 1'b1;
    else if (clr_rx)    hw_busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !init_n) ovr <= 1'b0;
    else if (ovr_ev)    ovr <= 1'b1;
    else if (clr_ovr)   ovr <= 1'b0;
  end
endmodule

// File: rtl/pport_csr.sv
module pport_csr
  import pport_rx_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [CMD_W-1:0]  cpu_wdata,
  input  logic [DATA_W-1:0] data_q,
  input  logic              hw_busy,
  input  logic              ovr,
  input  logic              busy_q,
  output logic              edge_sel,
  output logic              sw_busy,
  output logic              clr_rx,
  output logic              clr_ovr,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic              wr_stat;
  logic              wr_ctrl;
  logic              rd_en;
  logic [DATA_W-1:0] rd_mux;

  assign wr_stat = cpu_sel & cpu_wr & (cpu_addr == ADDR_STAT);
  assign wr_ctrl = cpu_sel & cpu_wr & (cpu_addr == ADDR_CTRL);
  assign rd_en   = cpu_sel & ~cpu_wr;

  assign clr_rx  = wr_stat & cpu_wdata[ST_RX];
  assign clr_ovr = wr_stat & cpu_wdata[ST_OVR];

  always_ff @(posedge clk) begin
    if (rst)          edge_sel <= 1'b0;
    else if (wr_ctrl) edge_sel <= cpu_wdata[CT_EDGE];
  end

  always_ff @(posedge clk) begin
    if (rst || !init_n) sw_busy <= 1'b1;
    else if (wr_ctrl)   sw_busy <= cpu_wdata[CT_SWB];
  end

  always_comb begin
    rd_mux = '0;
    case (cpu_addr)
      ADDR_DATA: rd_mux = data_q;
      ADDR_STAT: begin
        rd_mux[ST_RX]   = hw_busy;
        rd_mux[ST_OVR]  = ovr;
        rd_mux[ST_BUSY] = busy_q;
      end
      ADDR_CTRL: begin
        rd_mux[CT_EDGE] = edge_sel;
        rd_mux[CT_SWB]  = sw_busy;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        cpu_rdata <= '0;
    else if (rd_en) cpu_rdata <= rd_mux;
  end
endmodule

// File: rtl/pport_rx_hshk.sv
module pport_rx_hshk
  import pport_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = BYTE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_n,
  input  logic              strobe_n,
  input  logic [DATA_W-1:0] pdata,
  output logic              busy,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [CMD_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic              lead_w;
  logic              trail_w;
  logic              edge_sel;
  logic              sw_busy;
  logic              clr_rx;
  logic              clr_ovr;
  logic              hw_busy;
  logic              ovr;
  logic [DATA_W-1:0] data_q;
  logic              busy_q;

  pport_strb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (strobe_n),
    .lead     (lead_w),
    .trail    (trail_w)
  );

  pport_rx_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .init_n   (init_n),
    .lead     (lead_w),
    .trail    (trail_w),
    .edge_sel (edge_sel),
    .pdata    (pdata),
    .clr_rx   (clr_rx),
    .clr_ovr  (clr_ovr),
    .data_q   (data_q),
    .hw_busy  (hw_busy),
    .ovr      (ovr)
  );

  pport_csr #(.DATA_W(DATA_W)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .init_n    (init_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .data_q    (data_q),
    .hw_busy   (hw_busy),
    .ovr       (ovr),
    .busy_q    (busy_q),
    .edge_sel  (edge_sel),
    .sw_busy   (sw_busy),
    .clr_rx    (clr_rx),
    .clr_ovr   (clr_ovr),
    .cpu_rdata (cpu_rdata)
  );

  // merged host BUSY, registered
  always_ff @(posedge clk) begin
    if (rst || !init_n) busy_q <= 1'b1;
    else                busy_q <= hw_busy | sw_busy;
  end

  assign busy = busy_q;
endmodule

// File: rtl/pport_rx_hshk_chk.sv
module pport_rx_hshk_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              init_n,
  input logic              busy,
  input logic              lead,
  input logic              edge_sel,
  input logic              hw_busy,
  input logic              ovr,
  input logic              clr_ovr,
  input logic [DATA_W-1:0] data_q
);
  // R9
  init_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !init_n |=> busy);

  // R5
  hw_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
    hw_busy |=> busy);

  // R3
  lead_set_chk: assert property (@(posedge clk) disable iff (rst)
    (lead && !edge_sel && init_n) |=> hw_busy);

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (lead && hw_busy && init_n) |=> ovr);

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr && init_n && !clr_ovr) |=> ovr);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lead |=> $stable(data_q));
endmodule

bind pport_rx_hshk pport_rx_hshk_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .init_n   (init_n),
  .busy     (busy),
  .lead     (lead_w),
  .edge_sel (edge_sel),
  .hw_busy  (hw_busy),
  .ovr      (ovr),
  .clr_ovr  (clr_ovr),
  .data_q   (data_q)
);

// File: tb/pport_rx_hshk_bench.sv
`timescale 1ns/1ps
module pport_rx_hshk_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       init_n;
  logic       strobe_n;
  logic [7:0] pdata;
  logic       busy;
  logic       cpu_sel;
  logic       cpu_wr;
  logic [1:0] cpu_addr;
  logic [1:0] cpu_wdata;
  logic [7:0] cpu_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  bit started  = 0;

  always #4 clk = ~clk;

  pport_rx_hshk u_pport_rx_hshk (
    .clk       (clk),
    .rst       (rst),
    .init_n    (init_n),
    .strobe_n  (strobe_n),
    .pdata     (pdata),
    .busy      (busy),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata)
  );

  // behavioural reference model
  bit       hist[$];
  bit [7:0] m_data;
  bit       m_rx, m_ovr, m_edge, m_sw, m_busy;
  bit [7:0] m_rdata;

  always @(posedge clk) begin
    bit lead, trail, set_ev, old_rx;
    started = 1;
    if (rst) begin
      hist = '{1'b1, 1'b1, 1'b1};
      m_data = 0; m_rx = 0; m_ovr = 0; m_edge = 0; m_sw = 1;
      m_busy = 1; m_rdata = 0;
    end else begin
      // samples from two and three edges ago
      lead   = hist[2] && !hist[1];
      trail  = !hist[2] && hist[1];
      set_ev = m_edge ? trail : lead;
      old_rx = m_rx;
      if (cpu_sel && !cpu_wr) begin
        case (cpu_addr)
          2'd0: m_rdata = m_data;
          2'd1: m_rdata = {5'd0, m_busy, m_ovr, m_rx};
          2'd2: m_rdata = {6'd0, m_sw, m_edge};
          default: m_rdata = 8'd0;
        endcase
      end
      m_busy = !init_n ? 1'b1 : (m_rx | m_sw);
      if (cpu_sel && cpu_wr && cpu_addr == 2'd2) begin
        m_edge = cpu_wdata[0];
        m_sw   = cpu_wdata[1];
      end
      if (!init_n) begin
        m_sw = 1; m_rx = 0; m_ovr = 0;
      end else begin
        if (cpu_sel && cpu_wr && cpu_addr == 2'd1) begin
          if (cpu_wdata[0]) m_rx = 0;
          if (cpu_wdata[1]) m_ovr = 0;
        end
        if (set_ev) m_rx = 1;
        if (lead && old_rx) m_ovr = 1;
        if (lead) m_data = pdata;
      end
      hist.push_front(strobe_n);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      check("R5 busy vs model", {7'd0, busy}, {7'd0, m_busy});
      check("R10 rdata vs model", cpu_rdata, m_rdata);
    end
  end

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
    @(negedge clk); cpu_sel = 0; v = cpu_rdata;
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk); cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_sel = 0; cpu_wr = 0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int lo, input int hi);
    @(negedge clk); pdata = b; strobe_n = 0;
    repeat (lo) @(negedge clk);
    strobe_n = 1;
    repeat (hi) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1; init_n = 1; strobe_n = 1; pdata = 0;
    cpu_sel = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {7'd0, busy}, 8'h01);
    cpu_read(2'd0, v); check("R1 data", v, 8'h00);
    cpu_read(2'd1, v); check("R1 status", v, 8'h04);
    cpu_read(2'd2, v); check("R1 ctrl", v, 8'h02);

    // R5 firmware busy off drops BUSY
    cpu_write(2'd2, 2'b00);
    check("R5 busy low", {7'd0, busy}, 8'h00);

    // R2 / R3 leading-edge mode timing
    @(negedge clk); pdata = 8'hA5; strobe_n = 0;
    repeat (3) @(negedge clk);
    check("R3 busy not yet", {7'd0, busy}, 8'h00);
    @(negedge clk);
    check("R3 busy raised", {7'd0, busy}, 8'h01);
    strobe_n = 1; pdata = 8'h00;
    repeat (4) @(negedge clk);
    cpu_read(2'd0, v); check("R2 data latched", v, 8'hA5);
    cpu_read(2'd1, v); check("R3 status", v, 8'h05);
    cpu_read(2'd0, v);
    cpu_read(2'd1, v); check("R6 read no effect", v, 8'h05);

    // R6 clear
    cpu_write(2'd1, 2'b01);
    cpu_read(2'd1, v); check("R6 cleared", v, 8'h00);

    // R7 overrun
    send_byte(8'h11, 4, 4);
    send_byte(8'h22, 4, 4);
    cpu_read(2'd1, v); check("R7 overrun status", v, 8'h07);
    cpu_read(2'd0, v); check("R7 overwritten", v, 8'h22);
    cpu_write(2'd1, 2'b01);
    cpu_read(2'd1, v); check("R7 sticky", v, 8'h02);
    cpu_write(2'd1, 2'b10);
    cpu_read(2'd1, v); check("R7 ovr cleared", v, 8'h00);

    // R4 trailing-edge mode
    cpu_write(2'd2, 2'b01);
    @(negedge clk); pdata = 8'h3C; strobe_n = 0;
    repeat (5) @(negedge clk);
    check("R4 no busy on lead", {7'd0, busy}, 8'h00);
    cpu_read(2'd0, v); check("R4 data on lead", v, 8'h3C);
    cpu_read(2'd1, v); check("R4 flag clear while low", v, 8'h00);
    @(negedge clk); strobe_n = 1;
    repeat (3) @(negedge clk);
    check("R4 busy not yet", {7'd0, busy}, 8'h00);
    @(negedge clk);
    check("R4 busy raised", {7'd0, busy}, 8'h01);
    cpu_read(2'd1, v); check("R4 status", v, 8'h05);
    cpu_write(2'd1, 2'b01);
    cpu_write(2'd2, 2'b00);

    // R8 set wins over same-cycle clear
    send_byte(8'h44, 4, 4);
    @(negedge clk); pdata = 8'h55; strobe_n = 0;
    @(negedge clk);
    @(negedge clk); cpu_sel = 1; cpu_wr = 1; cpu_addr = 2'd1; cpu_wdata = 2'b11;
    @(negedge clk); cpu_sel = 0; cpu_wr = 0;
    @(negedge clk); strobe_n = 1;
    repeat (4) @(negedge clk);
    cpu_read(2'd1, v); check("R8 set beats clear", v, 8'h07);
    cpu_read(2'd0, v); check("R8 data", v, 8'h55);
    cpu_write(2'd1, 2'b11);
    cpu_read(2'd1, v); check("R8 cleared after", v, 8'h00);

    // R9 init
    cpu_write(2'd2, 2'b01);
    send_byte(8'h66, 4, 4);
    send_byte(8'h77, 4, 4);
    cpu_read(2'd1, v); check("R9 pre-init status", v, 8'h07);
    @(negedge clk); init_n = 0; pdata = 8'h88; strobe_n = 0;
    repeat (3) @(negedge clk);
    strobe_n = 1;
    repeat (5) @(negedge clk);
    init_n = 1;
    @(negedge clk);
    check("R9 busy", {7'd0, busy}, 8'h01);
    cpu_read(2'd2, v); check("R9 ctrl", v, 8'h03);
    cpu_read(2'd1, v); check("R9 status", v, 8'h04);
    cpu_read(2'd0, v); check("R9 no capture", v, 8'h77);

    // R10 unused address
    cpu_read(2'd3, v); check("R10 addr3", v, 8'h00);

    // random traffic, checked by the model every clock
    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 3) == 0)
        cpu_write(2'd2, 2'($urandom_range(0, 3)));
      send_byte(8'($urandom_range(0, 255)), $urandom_range(1, 5), $urandom_range(1, 8));
      if ($urandom_range(0, 1) == 1) cpu_write(2'd1, 2'($urandom_range(0, 3)));
      cpu_read(2'($urandom_range(0, 3)), v);
    end
    repeat (4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule